// File: doc/BRIEF.md
# Dual-Field Word-Serial Montgomery Multiplier

This block computes the Montgomery product A·B·R⁻¹ mod M for public-key arithmetic. One shared datapath handles two fields. In prime-field mode it uses integer arithmetic with carries. In binary-polynomial mode every addition becomes an exclusive-OR and every product is carry-less. The operand length is a run-time count of 32-bit words, so a larger key needs only deeper operand storage and no new datapath. Exponentiation sequencing, inversion and the computation of the word-level Montgomery constant are left to the surrounding logic.

The caller fills three external word buffers (A, B, M), supplies the word count, the field select and the constant m', and pulses `start`. The block reads operand words through its own address outputs, which expect combinational read data. It walks the words of A in an outer loop. For each word of A it makes one accumulate pass over B, forms the quotient word q, and makes one reduction pass over M that shifts the partial result down by one word. In prime-field mode it then compares the result with M and subtracts M once if needed. Finally it writes the result words, lowest address first, and pulses `done`.

The states are IDLE, MUL, MUL_TOP, QCALC, RED, RED_TOP, CHECK, WRITE and FIN. The transitions are:
- IDLE→MUL when `start` is high.
- MUL→MUL_TOP after the last word.
- MUL_TOP→QCALC.
- QCALC→RED.
- RED→RED_TOP after the last word.
- RED_TOP→MUL while words of A remain.
- RED_TOP→CHECK after the last word of A in prime-field mode, or RED_TOP→WRITE in polynomial mode.
- CHECK→WRITE after the last word.
- WRITE→FIN after the last word.
- FIN→IDLE.

Top module: `mm_mont_mul`

## Requirements
- R1: When `start` is high in the idle state, the block captures `nwords`, `field_poly` and `mprime`, and `busy` is high in the following cycle.
- R2: With `field_poly`=0 (prime field), M odd, A,B < M and `mprime` = −M⁻¹ mod 2³², the written result equals A·B·2^(−32·N) mod M and is fully reduced (less than M). N is the word count and word k occupies bits 32k+31..32k of each operand.
- R3: With `field_poly`=1 (binary polynomials), M with constant term 1, deg A and deg B below deg M, deg M < 32·N and `mprime` = M⁻¹ mod x³², the written result equals A·B·x^(−32·N) mod M. In this mode no final subtraction is done.
- R4: The word count N may be any value from 1 to NMAX. Exactly N result words are written, one per cycle, at addresses 0,1,…,N−1 in ascending order, and only while `busy` is high.
- R5: `done` is a single-cycle pulse in the cycle that follows the last result write.
- R6: A `start` pulse that arrives while `busy` is high is ignored. The running operation keeps its word count, field and constant, and its result and timing are unchanged.
- R7: Counting clock edges after the edge that captures `start`, `done` is first high after N·(2N+3)+2N edges in prime-field mode and N·(2N+3)+N edges in polynomial mode.
- R8: After reset, `busy`, `done` and `res_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (ignored while busy) |
| field_poly | input | 1 | 0: prime field, 1: binary polynomial field |
| nwords | input | $clog2(NMAX+1) | Operand length in words, 1..NMAX |
| mprime | input | W | Word-level Montgomery constant |
| a_addr | output | $clog2(NMAX) | Word address into the A buffer |
| a_rdata | input | W | A word at `a_addr` (combinational) |
| b_addr | output | $clog2(NMAX) | Word address into the B buffer |
| b_rdata | input | W | B word at `b_addr` (combinational) |
| m_addr | output | $clog2(NMAX) | Word address into the modulus buffer |
| m_rdata | input | W | M word at `m_addr` (combinational) |
| res_we | output | 1 | Result word write strobe |
| res_addr | output | $clog2(NMAX) | Result word address |
| res_wdata | output | W | Result word |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Completion pulse |

## Verification
The partial-result words are folded into every later pass. An error in a carry, a quotient word or a shift index therefore shows up as a wrong result word at the final write, and the error usually spreads through most words, not only one. A wrong state transition changes the cycle count to `done` or the number and order of writes, and these show up at the ports within one operation. A mistake in the final comparison appears only when the unreduced result lies between M and 2M, so directed operands near M are mixed with random ones. Both fields are run at 1, 2, 4 and 8 words, and `start` is pulsed in the middle of some runs.

// File: rtl/mm_pkg.sv
package mm_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_MUL,
        S_MUL_TOP,
        S_QCALC,
        S_RED,
        S_RED_TOP,
        S_CHECK,
        S_WRITE,
        S_FIN
    } mm_state_e;

endpackage

// File: rtl/mm_mac.sv
// Dual-field word multiply-accumulate: {hi,lo} = x*y + acc + cin (integer)
// or clmul(x,y) ^ (acc ^ cin) (carry-less).
module mm_mac #(
    parameter int W = 32
) (
    input  logic         poly,
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic [W-1:0] acc,
    input  logic [W-1:0] cin,
    output logic [W-1:0] hi,
    output logic [W-1:0] lo
);

    logic [2*W-1:0] prod_int;
    logic [2*W-1:0] prod_cl;
    logic [2*W-1:0] res;

    always_comb begin
        prod_cl = '0;
        for (int k = 0; k < W; k++) begin
            if (y[k]) begin
                prod_cl = prod_cl ^ ({{W{1'b0}}, x} << k);
            end
        end
    end

    always_comb begin
        prod_int = {{W{1'b0}}, x} * {{W{1'b0}}, y}
                 + {{W{1'b0}}, acc} + {{W{1'b0}}, cin};
    end

    always_comb begin
        res = poly ? (prod_cl ^ {{W{1'b0}}, acc ^ cin}) : prod_int;
        hi  = res[2*W-1:W];
        lo  = res[W-1:0];
    end

endmodule

// File: rtl/mm_sub.sv
// One word of a borrow-chained subtraction: d = a - b - bin.
module mm_sub #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         bin,
    output logic [W-1:0] d,
    output logic         bout
);

    logic [W:0] diff;

    always_comb begin
        diff = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, bin};
        d    = diff[W-1:0];
        bout = diff[W];
    end

endmodule

// File: rtl/mm_mont_mul.sv
module mm_mont_mul
    import mm_pkg::*;
#(
    parameter int W = 32,
    parameter int NMAX = 8,
    localparam int CW = $clog2(NMAX + 1),
    localparam int AW = $clog2(NMAX),
    localparam int IW = $clog2(NMAX + 2)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          field_poly,
    input  logic [CW-1:0] nwords,
    input  logic [W-1:0]  mprime,
    output logic [AW-1:0] a_addr,
    input  logic [W-1:0]  a_rdata,
    output logic [AW-1:0] b_addr,
    input  logic [W-1:0]  b_rdata,
    output logic [AW-1:0] m_addr,
    input  logic [W-1:0]  m_rdata,
    output logic          res_we,
    output logic [AW-1:0] res_addr,
    output logic [W-1:0]  res_wdata,
    output logic          busy,
    output logic          done
);

    localparam int TD = NMAX + 2;
    localparam logic [IW-1:0] ONE = IW'(1);

    mm_state_e state, state_n;

    logic [IW-1:0] nw_q;
    logic          poly_q;
    logic [W-1:0]  mp_q;
    logic [IW-1:0] i_q;
    logic [IW-1:0] j_q;
    logic [W-1:0]  c_q;
    logic [W-1:0]  q_q;
    logic          brw_q;
    logic          ge_q;
    logic [W-1:0]  t_q [TD];

    logic          last_j, last_i;
    logic [W-1:0]  t_j, t_top, t_ext;
    logic [W-1:0]  mx, my, macc, mcin, mac_hi, mac_lo;
    logic [W-1:0]  sub_d;
    logic          sub_bout;

    assign last_j = (j_q == nw_q - ONE);
    assign last_i = (i_q == nw_q - ONE);
    assign t_j    = t_q[j_q];
    assign t_top  = t_q[nw_q];
    assign t_ext  = t_q[nw_q + ONE];

    mm_mac #(.W(W)) u_mac (
        .poly (poly_q),
        .x    (mx),
        .y    (my),
        .acc  (macc),
        .cin  (mcin),
        .hi   (mac_hi),
        .lo   (mac_lo)
    );

    mm_sub #(.W(W)) u_sub (
        .a    (t_j),
        .b    (m_rdata),
        .bin  (brw_q),
        .d    (sub_d),
        .bout (sub_bout)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= state_n;
        end
    end

    // next-state logic
    always_comb begin
        state_n = state;
        unique case (state)
            S_IDLE:    if (start) state_n = S_MUL;
            S_MUL:     if (last_j) state_n = S_MUL_TOP;
            S_MUL_TOP: state_n = S_QCALC;
            S_QCALC:   state_n = S_RED;
            S_RED:     if (last_j) state_n = S_RED_TOP;
            S_RED_TOP: begin
                if (!last_i) begin
                    state_n = S_MUL;
                end else if (poly_q) begin
                    state_n = S_WRITE;
                end else begin
                    state_n = S_CHECK;
                end
            end
            S_CHECK:   if (last_j) state_n = S_WRITE;
            S_WRITE:   if (last_j) state_n = S_FIN;
            S_FIN:     state_n = S_IDLE;
            default:   state_n = S_IDLE;
        endcase
    end

    // arithmetic operand selection
    always_comb begin
        mx   = '0;
        my   = '0;
        macc = '0;
        mcin = '0;
        unique case (state)
            S_MUL: begin
                mx   = a_rdata;
                my   = b_rdata;
                macc = t_j;
                mcin = c_q;
            end
            S_MUL_TOP, S_RED_TOP: begin
                macc = t_top;
                mcin = c_q;
            end
            S_QCALC: begin
                mx = t_q[0];
                my = mp_q;
            end
            S_RED: begin
                mx   = q_q;
                my   = m_rdata;
                macc = t_j;
                mcin = c_q;
            end
            default: ;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nw_q   <= '0;
            poly_q <= 1'b0;
            mp_q   <= '0;
            i_q    <= '0;
            j_q    <= '0;
            c_q    <= '0;
            q_q    <= '0;
            brw_q  <= 1'b0;
            ge_q   <= 1'b0;
            for (int k = 0; k < TD; k++) t_q[k] <= '0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (start) begin
                        nw_q   <= IW'(nwords);
                        poly_q <= field_poly;
                        mp_q   <= mprime;
                        i_q    <= '0;
                        j_q    <= '0;
                        c_q    <= '0;
                        brw_q  <= 1'b0;
                        ge_q   <= 1'b0;
                        for (int k = 0; k < TD; k++) t_q[k] <= '0;
                    end
                end
                S_MUL: begin
                    t_q[j_q] <= mac_lo;
                    c_q      <= mac_hi;
                    j_q      <= last_j ? '0 : j_q + ONE;
                end
                S_MUL_TOP: begin
                    t_q[nw_q]       <= mac_lo;
                    t_q[nw_q + ONE] <= mac_hi;
                    c_q             <= '0;
                end
                S_QCALC: begin
                    q_q <= mac_lo;
                end
                S_RED: begin
                    if (j_q != '0) t_q[j_q - ONE] <= mac_lo;
                    c_q <= mac_hi;
                    j_q <= last_j ? '0 : j_q + ONE;
                end
                S_RED_TOP: begin
                    t_q[nw_q - ONE] <= mac_lo;
                    t_q[nw_q]       <= poly_q ? (t_ext ^ mac_hi) : (t_ext + mac_hi);
                    t_q[nw_q + ONE] <= '0;
                    c_q             <= '0;
                    i_q             <= i_q + ONE;
                    j_q             <= '0;
                    brw_q           <= 1'b0;
                    ge_q            <= 1'b0;
                end
                S_CHECK: begin
                    j_q   <= last_j ? '0 : j_q + ONE;
                    brw_q <= last_j ? 1'b0 : sub_bout;
                    if (last_j) ge_q <= (t_top != '0) || !sub_bout;
                end
                S_WRITE: begin
                    brw_q <= sub_bout;
                    j_q   <= j_q + ONE;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy      = (state != S_IDLE);
        done      = (state == S_FIN);
        res_we    = (state == S_WRITE);
        res_addr  = j_q[AW-1:0];
        res_wdata = ge_q ? sub_d : t_j;
        a_addr    = i_q[AW-1:0];
        b_addr    = j_q[AW-1:0];
        m_addr    = j_q[AW-1:0];
    end

endmodule

// File: rtl/mm_mont_mul_chk.sv
module mm_mont_mul_chk #(
    parameter int NMAX = 8,
    localparam int AW = $clog2(NMAX),
    localparam int IW = $clog2(NMAX + 2)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic          res_we,
    input logic [AW-1:0] res_addr,
    input logic [IW-1:0] nw_q,
    input logic          poly_q
);

    AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy) else $error("busy did not follow start"); // R1

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (start && busy) |=> ($stable(nw_q) && $stable(poly_q))) else $error("start taken while busy"); // R6

    AST_WE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        res_we |-> busy) else $error("write outside operation"); // R4

    AST_WADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        res_we |-> (IW'(res_addr) < nw_q)) else $error("write address beyond length"); // R4

    AST_WADDR_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (res_we && $past(res_we)) |-> (res_addr == $past(res_addr) + AW'(1))) else $error("write order broken"); // R4

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done) else $error("done longer than one cycle"); // R5

    AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(res_we)) else $error("done not after last write"); // R5

endmodule

bind mm_mont_mul mm_mont_mul_chk #(.NMAX(NMAX)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .res_we   (res_we),
    .res_addr (res_addr),
    .nw_q     (nw_q),
    .poly_q   (poly_q)
);

// File: tb/sim_mm_mont_mul.sv
module sim_mm_mont_mul;

    localparam int CLK_PERIOD = 10;
    localparam int W = 32;
    localparam int NMAX = 8;
    localparam int CW = $clog2(NMAX + 1);
    localparam int AW = $clog2(NMAX);
    localparam int BW = 512;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          field_poly = 1'b0;
    logic [CW-1:0] nwords = '0;
    logic [W-1:0]  mprime = '0;
    logic [AW-1:0] a_addr, b_addr, m_addr, res_addr;
    logic [W-1:0]  a_rdata, b_rdata, m_rdata, res_wdata;
    logic          res_we, busy, done;

    logic [W-1:0] a_mem [NMAX];
    logic [W-1:0] b_mem [NMAX];
    logic [W-1:0] m_mem [NMAX];
    logic [W-1:0] res_mem [NMAX];
    int           wcount = 0;

    int errors = 0;
    int checks = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    assign a_rdata = a_mem[a_addr];
    assign b_rdata = b_mem[b_addr];
    assign m_rdata = m_mem[m_addr];

    always @(posedge clk) begin
        if (res_we) begin
            res_mem[res_addr] <= res_wdata;
            wcount <= wcount + 1;
        end
    end

    mm_mont_mul #(.W(W), .NMAX(NMAX)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .field_poly (field_poly),
        .nwords     (nwords),
        .mprime     (mprime),
        .a_addr     (a_addr),
        .a_rdata    (a_rdata),
        .b_addr     (b_addr),
        .b_rdata    (b_rdata),
        .m_addr     (m_addr),
        .m_rdata    (m_rdata),
        .res_we     (res_we),
        .res_addr   (res_addr),
        .res_wdata  (res_wdata),
        .busy       (busy),
        .done       (done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [BW-1:0] act, input logic [BW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [BW-1:0] clmul_big(input logic [BW-1:0] a, input logic [BW-1:0] b);
        logic [BW-1:0] r = '0;
        for (int k = 0; k < 256; k++) if (b[k]) r = r ^ (a << k);
        return r;
    endfunction

    function automatic logic [BW-1:0] poly_mod(input logic [BW-1:0] t, input logic [BW-1:0] m);
        int d = 0;
        logic [BW-1:0] r = t;
        for (int k = 0; k < BW; k++) if (m[k]) d = k;
        for (int k = BW - 1; k >= d; k--) if (r[k]) r = r ^ (m << (k - d));
        return r;
    endfunction

    function automatic logic [BW-1:0] model(input bit poly, input int n, input logic [BW-1:0] a,
                                            input logic [BW-1:0] b, input logic [BW-1:0] m);
        logic [BW-1:0] t;
        if (poly) begin
            t = clmul_big(a, b);
            for (int s = 0; s < 32 * n; s++) begin
                if (t[0]) t = t ^ m;
                t = t >> 1;
            end
            t = poly_mod(t, m);
        end else begin
            t = (a * b) % m;
            for (int s = 0; s < 32 * n; s++) begin
                if (t[0]) t = (t + m) >> 1;
                else t = t >> 1;
            end
        end
        return t;
    endfunction

    function automatic logic [31:0] inv_neg(input logic [31:0] m0);
        logic [31:0] x = 32'd1;
        for (int k = 0; k < 5; k++) x = x * (32'd2 - m0 * x);
        return -x;
    endfunction

    function automatic logic [31:0] clmul_lo(input logic [31:0] a, input logic [31:0] b);
        logic [31:0] r = '0;
        for (int k = 0; k < 32; k++) if (b[k]) r = r ^ (a << k);
        return r;
    endfunction

    function automatic logic [31:0] inv_poly(input logic [31:0] m0);
        logic [31:0] y = '0;
        for (int k = 0; k < 32; k++) begin
            logic [31:0] p = clmul_lo(m0, y);
            if (p[k] != (k == 0)) y[k] = 1'b1;
        end
        return y;
    endfunction

    function automatic logic [BW-1:0] rand_big(input int n);
        logic [BW-1:0] r = '0;
        for (int k = 0; k < n; k++) r[32*k +: 32] = $urandom;
        return r;
    endfunction

    task automatic run_case(input bit poly, input int n, input logic [BW-1:0] a,
                            input logic [BW-1:0] b, input logic [BW-1:0] m, input bit inject);
        logic [BW-1:0] exp_v, got;
        int cnt, wbase, lat;
        string rq;
        rq = poly ? "R3" : "R2";
        for (int k = 0; k < NMAX; k++) begin
            a_mem[k] = a[32*k +: 32];
            b_mem[k] = b[32*k +: 32];
            m_mem[k] = m[32*k +: 32];
        end
        exp_v = model(poly, n, a, b, m);
        lat   = n * (2 * n + 3) + (poly ? n : 2 * n);
        @(negedge clk);
        field_poly = poly;
        nwords     = CW'(n);
        mprime     = poly ? inv_poly(m[31:0]) : inv_neg(m[31:0]);
        start      = 1'b1;
        wbase      = wcount;
        @(posedge clk);
        #1;
        start = 1'b0;
        check(busy == 1'b1, "R1", "busy after start", BW'(busy), BW'(1));
        cnt = 0;
        while (1) begin
            @(posedge clk);
            #1;
            cnt++;
            if (inject && cnt == 3) begin
                start = 1'b1;
                nwords = CW'(1);
                field_poly = ~poly;
            end
            if (inject && cnt == 4) begin
                start = 1'b0;
                nwords = CW'(n);
                field_poly = poly;
            end
            if (done) break;
            if (cnt > 4000) break;
        end
        check(done == 1'b1 && cnt == lat, "R7", "cycles to done", BW'(cnt), BW'(lat));
        if (inject) check(cnt == lat, "R6", "latency with start while busy", BW'(cnt), BW'(lat));
        @(posedge clk);
        #1;
        check(done == 1'b0, "R5", "done single cycle", BW'(done), BW'(0));
        got = '0;
        for (int k = 0; k < n; k++) got[32*k +: 32] = res_mem[k];
        check(got == exp_v, rq, "result", got, exp_v);
        if (inject) check(got == exp_v, "R6", "result with start while busy", got, exp_v);
        check(wcount - wbase == n, "R4", "write count", BW'(wcount - wbase), BW'(n));
    endtask

    task automatic rand_case(input bit poly, input int n, input bit inject);
        logic [BW-1:0] m, a, b;
        m = rand_big(n);
        m[0] = 1'b1;
        if (poly) begin
            m[32*n - 1] = 1'b0;
            m[32*n - 2] = 1'b1;
            a = poly_mod(rand_big(n), m);
            b = poly_mod(rand_big(n), m);
        end else begin
            m[32*n - 1] = 1'b1;
            a = rand_big(n) % m;
            b = rand_big(n) % m;
        end
        run_case(poly, n, a, b, m, inject);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [BW-1:0] m;
        void'($urandom(32'd20240611));
        for (int k = 0; k < NMAX; k++) begin
            a_mem[k] = '0;
            b_mem[k] = '0;
            m_mem[k] = '0;
        end
        repeat (3) @(posedge clk);
        #1;
        check(busy == 1'b0 && done == 1'b0 && res_we == 1'b0, "R8", "outputs in reset",
              BW'({busy, done, res_we}), BW'(0));
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check(busy == 1'b0 && done == 1'b0 && res_we == 1'b0, "R8", "idle after reset",
              BW'({busy, done, res_we}), BW'(0));

        // random operands, both fields, R2/R3/R4 lengths 2,4,8
        for (int r = 0; r < 3; r++) rand_case(1'b0, 2, 1'b0);
        for (int r = 0; r < 3; r++) rand_case(1'b0, 4, 1'b0);
        for (int r = 0; r < 2; r++) rand_case(1'b0, 8, 1'b0);
        for (int r = 0; r < 3; r++) rand_case(1'b1, 2, 1'b0);
        for (int r = 0; r < 3; r++) rand_case(1'b1, 4, 1'b0);
        for (int r = 0; r < 2; r++) rand_case(1'b1, 8, 1'b0);
        // single-word length (R4)
        rand_case(1'b0, 1, 1'b0);
        rand_case(1'b1, 1, 1'b0);

        // directed: R2 operands at M-1, zero operand
        m = rand_big(2);
        m[0] = 1'b1;
        m[63] = 1'b1;
        run_case(1'b0, 2, m - 1, m - 1, m, 1'b0);
        m = rand_big(4);
        m[0] = 1'b1;
        m[127] = 1'b1;
        run_case(1'b0, 4, '0, m - 2, m, 1'b0);
        // small modulus forces the final subtraction path often (R2)
        m = '0;
        m[63:0] = 64'h0000_0001_0000_0003;
        run_case(1'b0, 2, 512'h0000_0001_0000_0001, 512'h0000_0001_0000_0002, m, 1'b0);
        // directed: R3 unit and zero operands
        m = rand_big(2);
        m[0] = 1'b1;
        m[63] = 1'b0;
        m[62] = 1'b1;
        run_case(1'b1, 2, 512'd1, 512'd1, m, 1'b0);
        run_case(1'b1, 2, '0, 512'd5, m, 1'b0);

        // start pulsed while busy (R6)
        rand_case(1'b0, 4, 1'b1);
        rand_case(1'b1, 2, 1'b1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule